// File: doc/BRIEF.md
# Two-Bit Saturating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of two-bit saturating counters, and the low bits of the branch address select one counter. A fetch-side lookup port takes a program counter and returns the guess in the same cycle. The guess is the upper bit of the selected counter, and the port also exposes the whole counter value.

A separate resolve port takes the address of a branch that has finished executing, together with its real direction. On the next clock edge it moves the selected counter one step toward that direction. Each direction has a strong state and a weak state, so a branch that is usually taken keeps its taken guess through a single not-taken outcome. All counters come out of reset in the weakly-taken state.

The block is meant to sit beside a target-address cache in the fetch stage. It stores no tags: two branches whose index bits match share one counter.

Top module: `bp2_predictor`

## Requirements
- R1: After reset, every table entry holds the weakly-taken value 2'b10, so every lookup returns predState=2'b10 and predTaken=1.
- R2: The counter encoding is 2'b00 strongly not-taken, 2'b01 weakly not-taken, 2'b10 weakly taken and 2'b11 strongly taken. predTaken equals bit 1 of the looked-up counter.
- R3: A resolved taken outcome (updValid=1, updTaken=1) raises the addressed counter by one. A counter already at 2'b11 stays at 2'b11.
- R4: A resolved not-taken outcome (updValid=1, updTaken=0) lowers the addressed counter by one. A counter already at 2'b00 stays at 2'b00.
- R5: A single outcome that disagrees with a strong state does not change the guess. From 2'b11, one not-taken outcome gives 2'b10, which still predicts taken. From 2'b00, one taken outcome gives 2'b01, which still predicts not-taken.
- R6: The entry is selected by PC bits [IDX_W+1:2]. PC bits [1:0] and the bits above IDX_W+1 have no effect, so addresses that agree in the index bits share one counter.
- R7: When lookup and resolve address the same entry in one cycle, the lookup returns the value held before the update. The updated value appears in the following cycle.
- R8: While updValid=0, no counter changes.
- R9: Take a loop branch run repeatedly for N iterations, taken N-1 times and then not taken once, starting from weakly taken. Only the exit iteration is mispredicted.
- R10: A strictly alternating taken/not-taken stream that starts with taken from weakly taken is mispredicted on every not-taken outcome and on no taken outcome, so accuracy is 50%.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| predPc | input | PC_W | Fetch address to look up |
| predTaken | output | 1 | Guessed direction for predPc (1 = taken) |
| predState | output | 2 | Counter value currently selected by predPc |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Real direction of the resolved branch (1 = taken) |

## Verification
Directed sequences cover the following patterns:
- Long runs of one direction drive a counter into both saturation limits.
- A single contrary outcome after a strong state separates a two-bit counter from a one-bit last-outcome scheme.
- Aliasing addresses differ only in ignored bits, which shows that those bits are not decoded.
- Same-entry lookup and resolve in one cycle shows the read-before-write order.

A repeated five-iteration loop should miss only at its exits, and an alternating stream should miss on exactly half its outcomes. Together these confirm the hysteresis behaviour over time. A long mixed random phase packs lookups and resolves onto a few entries, with idle update cycles in between, and compares every lookup against a bench model of the counter table.

// File: rtl/bp2_pkg.sv
package bp2_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Strobes from control to the counter table
  typedef struct packed {
    logic wrEn;    // apply a step to the addressed entry
    logic stepUp;  // 1: toward taken, 0: toward not-taken
  } updStrobe_t;

  // One saturating step toward the resolved direction
  function automatic ctr_t satStep(input ctr_t cur, input logic up);
    ctr_t nxt;
    if (up) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else    nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp2_ctrl.sv
module bp2_ctrl
  import bp2_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  predPc,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic             updTaken,
  output logic [IDX_W-1:0] predIdx,
  output logic [IDX_W-1:0] updIdx,
  output updStrobe_t       strobe
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  // Bits outside the index window are deliberately not decoded
  logic unusedPcBits;
  assign unusedPcBits = ^{predPc[PC_W-1:IDX_HI+1], predPc[IDX_LO-1:0],
                          updPc[PC_W-1:IDX_HI+1],  updPc[IDX_LO-1:0]};

  assign predIdx = predPc[IDX_HI:IDX_LO];
  assign updIdx  = updPc[IDX_HI:IDX_LO];

  always_comb begin
    strobe        = '0;
    strobe.wrEn   = updValid;
    strobe.stepUp = updTaken;
  end

endmodule

// File: rtl/bp2_table.sv
module bp2_table
  import bp2_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] predIdx,
  input  logic [IDX_W-1:0] updIdx,
  input  updStrobe_t       strobe,
  output ctr_t             predState
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctrs [DEPTH];
  ctr_t updOld;
  ctr_t updNew;

  assign updOld = ctrs[updIdx];
  assign updNew = satStep(updOld, strobe.stepUp);

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrs[i] <= CTR_WEAK_T;
      else if (strobe.wrEn && (updIdx == IDX_W'(i)))
        ctrs[i] <= updNew;
    end
  end

  // Combinational read: same-cycle lookup sees the pre-update value
  assign predState = ctrs[predIdx];

endmodule

// File: rtl/bp2_predictor.sv
module bp2_predictor
  import bp2_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic [1:0]      predState,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  logic [IDX_W-1:0] predIdx;
  logic [IDX_W-1:0] updIdx;
  updStrobe_t       strobe;
  ctr_t             lookState;

  bp2_ctrl #(.PC_W(PC_W), .IDX_W(IDX_W)) uCtrl (
    .predPc   (predPc),
    .updValid (updValid),
    .updPc    (updPc),
    .updTaken (updTaken),
    .predIdx  (predIdx),
    .updIdx   (updIdx),
    .strobe   (strobe)
  );

  bp2_table #(.IDX_W(IDX_W)) uTable (
    .clk       (clk),
    .rst_n     (rst_n),
    .predIdx   (predIdx),
    .updIdx    (updIdx),
    .strobe    (strobe),
    .predState (lookState)
  );

  assign predState = lookState;
  assign predTaken = lookState[1];

endmodule

// File: rtl/bp2_predictor_chk.sv
module bp2_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] predPc,
  input logic            predTaken,
  input logic [1:0]      predState,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken
);

  logic armed;
  logic sameIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign sameIdx = (predPc[IDX_W+1:2] == updPc[IDX_W+1:2]);

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && updValid && updTaken && sameIdx && (predState != 2'b11)
    |=> (!$stable(predPc) || predState == $past(predState) + 2'd1));

  // R3
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && updValid && updTaken && sameIdx && (predState == 2'b11)
    |=> (!$stable(predPc) || predState == 2'b11));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && updValid && !updTaken && sameIdx && (predState != 2'b00)
    |=> (!$stable(predPc) || predState == $past(predState) - 2'd1));

  // R4
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && updValid && !updTaken && sameIdx && (predState == 2'b00)
    |=> (!$stable(predPc) || predState == 2'b00));

  // R5
  strong_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && updValid && !updTaken && sameIdx && (predState == 2'b11)
    |=> (!$stable(predPc) || predTaken));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !updValid
    |=> (!$stable(predPc) || $stable(predState)));

endmodule

bind bp2_predictor bp2_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .predPc    (predPc),
  .predTaken (predTaken),
  .predState (predState),
  .updValid  (updValid),
  .updPc     (updPc),
  .updTaken  (updTaken)
);

// File: tb/bp2_predictor_test.sv
module bp2_predictor_test;

  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] predPc = '0;
  logic            predTaken;
  logic [1:0]      predState;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [1:0] model [DEPTH];
  logic lastPred;

  always #10 clk = ~clk;

  bp2_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(predTaken),
    .predState(predState), .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic int idxOf(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [1:0] expStep(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? 2'b11 : c + 2'b01;
    return (c == 2'b00) ? 2'b00 : c - 2'b01;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle; check lookup against the model before the edge
  task automatic cycle(input logic [PC_W-1:0] pp, input logic uv,
                       input logic [PC_W-1:0] up, input logic ut,
                       input string req, input bit doChk);
    @(negedge clk);
    predPc = pp; updValid = uv; updPc = up; updTaken = ut;
    #1;
    lastPred = predTaken;
    if (doChk) begin
      check({req, " state"}, predState, model[idxOf(pp)]);
      check({req, " R2 taken"}, predTaken, model[idxOf(pp)][1]);
    end
    @(posedge clk);
    if (uv) model[idxOf(up)] = expStep(model[idxOf(up)], ut);
  endtask

  task automatic peek(input logic [PC_W-1:0] pp, input string req, input int exp);
    @(negedge clk);
    predPc = pp; updValid = 1'b0;
    #1;
    check(req, predState, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int miss;
    logic [PC_W-1:0] pa;
    logic [PC_W-1:0] pb;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < DEPTH; i++) model[i] = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every entry weakly taken
    for (int i = 0; i < DEPTH; i++) peek(PC_W'(i << 2), "R1 reset", 2);

    // R3: saturate upward at entry 1
    pa = 32'h0000_0004;
    for (int i = 0; i < 3; i++) cycle(pa, 1'b1, pa, 1'b1, "R3", 1);
    peek(pa, "R3 saturated high", 3);

    // R5: one not-taken from strong taken keeps taken guess
    cycle(pa, 1'b1, pa, 1'b0, "R5", 1);
    peek(pa, "R5 weak taken", 2);
    check("R5 still taken", predTaken, 1);

    // R4: saturate downward at entry 3
    pa = 32'h0000_000C;
    for (int i = 0; i < 4; i++) cycle(pa, 1'b1, pa, 1'b0, "R4", 1);
    peek(pa, "R4 saturated low", 0);
    cycle(pa, 1'b1, pa, 1'b1, "R5", 1);
    peek(pa, "R5 weak not-taken", 1);
    check("R5 still not-taken", predTaken, 0);

    // R6: alias through ignored bits
    pa = 32'hABCD_0017; // index 5
    pb = 32'h0000_0014; // index 5
    cycle(pb, 1'b1, pa, 1'b1, "R6", 1);
    peek(pb, "R6 alias shares counter", 3);
    peek(32'h0000_0018, "R6 neighbour untouched", 2);

    // R7: same-entry lookup and update in one cycle
    pa = 32'h0000_0020;
    cycle(pa, 1'b1, pa, 1'b0, "R7 pre-update", 1);
    check("R7 old value seen", predState, 2);
    peek(pa, "R7 new value next cycle", 1);

    // R8: no change while updValid is low
    pa = 32'h0000_0030;
    @(negedge clk);
    predPc = pa; updValid = 1'b0; updPc = pa; updTaken = 1'b1;
    @(negedge clk);
    updTaken = 1'b0;
    @(negedge clk);
    #1;
    check("R8 idle ignored", predState, 2);

    // R9: loop of 5 iterations repeated 4 times
    pa = 32'h0000_00A0;
    miss = 0;
    for (int r = 0; r < 4; r++)
      for (int it = 0; it < 5; it++) begin
        cycle(pa, 1'b1, pa, (it != 4), "R9", 1);
        if (lastPred != (it != 4)) miss++;
      end
    check("R9 loop misses", miss, 4);

    // R10: alternating stream from weakly taken
    pa = 32'h0000_00C8;
    miss = 0;
    for (int k = 0; k < 10; k++) begin
      cycle(pa, 1'b1, pa, (k % 2 == 0), "R10", 1);
      if (lastPred != (k % 2 == 0)) miss++;
    end
    check("R10 alternating misses", miss, 5);

    // Random mix over a few crowded entries (R2, R3, R4, R7, R8)
    for (int n = 0; n < 3000; n++) begin
      pa = ($urandom & 32'hFFFF_FF00) | (($urandom % 8) << 2) | ($urandom % 4);
      pb = ($urandom & 32'hFFFF_FF00) | (($urandom % 8) << 2) | ($urandom % 4);
      cycle(pa, ($urandom % 4) != 0, pb, $urandom % 2, "R2 random", 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule